// File: doc/BRIEF.md
# Local Command Decoder with Built-in Test Station

This block sits behind a 32 KB host window of a crate controller. Every host access carries an address, a size code, a direction flag and write data. The block splits the address into station number (N), sub-address (A) and function (F) fields. The top function bit (F16) is not taken from the address: it follows the direction of the access, so a write gives F16 = 1 and a read gives F16 = 0.

When N equals the configured test station, the block answers the controller's self-test functions. These are a ping that returns Q and X, a ping with a magic value that raises a LAM pulse, a loadable 4-bit test counter, a zero-returning read, and a fast-read function that counts the test counter down. Host software uses these functions to check the link and the controller without a module in the crate. Every reply comes back one cycle after the request, as a registered acknowledge with read data, Q and X.

Top module: `naf_test_station`

## Requirements
- R1: The station number is taken from address bits 14:10, the sub-address from bits 9:6 and the low four function bits from bits 5:2. Address bits 1:0 have no effect on decoding or on the reply.
- R2: The size code is 2'b01 for a word and 2'b10 for a longword. A byte access (2'b00) or the reserved code 2'b11 is never acknowledged and changes no state.
- R3: An access whose station field differs from parameter STATION_N (default 24) is not acknowledged and changes no state.
- R4: An accepted access raises rsp_ack for exactly one cycle, in the cycle after the request is sampled. While rsp_ack is low, rsp_q, rsp_x and rsp_rdata are all zero.
- R5: F16 is set by the direction and not by the address. The function code is {req_write, addr[5:2]}, so a write with F field 0 is F16 and a read with F field 0 is F0.
- R6: A write to A0 F16 whose data bits 15:0 are not 5 replies with Q=1 and X=1 and leaves lam_pulse unchanged.
- R7: A write to A0 F16 whose data bits 15:0 equal 5 replies with Q=0 and X=1. It drives lam_pulse high for LAM_CYCLES cycles (default 40, which is 200 ns at 200 MHz), starting in the reply cycle. A new trigger while the pulse is high restarts the full length.
- R8: A write to A1 F16 loads the test counter with data bits 3:0 and replies with Q=1 and X=1.
- R9: A read at A0 F0 replies with data 0, Q=1 and X=1.
- R10: A read at A1 F5 returns the counter value held before the access in data bits 3:0, with X=1 and Q=1 only when that value is nonzero. The counter then decrements, and it stays at 0 when it is already 0. The counter resets to 0.
- R11: A word read returns its 16-bit value in bits 15:0 with bits 31:16 zero. A longword read returns the same 16-bit value in both halves. A write uses data bits 15:0 only.
- R12: Any other A/F combination at the test station is acknowledged with Q=0, X=0 and data 0, and changes neither the counter nor lam_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe, one cycle per access |
| req_addr | input | 15 | Byte offset inside the 32 KB window |
| req_size | input | 2 | Access size code (00 byte, 01 word, 10 longword, 11 reserved) |
| req_write | input | 1 | 1 = write (F16 set), 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Access acknowledge, one cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_q | output | 1 | Q response |
| rsp_x | output | 1 | X response |
| lam_pulse | output | 1 | Stretched LAM request from the test station |

## Verification
The ping is driven with data 5, with other values, and with 5 placed only in the upper half of a longword. This separates a full 32-bit compare from the required 16-bit compare, and it exposes a LAM raised on the wrong data. The counter is loaded with a value that has junk in its upper bits, then counted down through zero. A fast read repeated at zero shows saturation, and a longword read shows the duplicated halves. The same load and trigger accesses are also sent with byte size, reserved size, a neighbouring station number and an unused A/F pair. A following fast read then shows through the normal interface that none of these touched the counter.

// File: rtl/naf_pkg.sv
package naf_pkg;
  localparam int F_LSB  = 2;
  localparam int F_W    = 4;
  localparam int A_W    = 4;
  localparam int N_W    = 5;
  localparam int A_LSB  = F_LSB + F_W;
  localparam int N_LSB  = A_LSB + A_W;
  localparam int ADDR_W = N_LSB + N_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    OP_OTHER,
    OP_PING,
    OP_LOAD,
    OP_ZERO_RD,
    OP_FAST_RD
  } test_op_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic [F_W:0]   f;   // bit F_W is the direction-derived F16
  } naf_t;
endpackage

// File: rtl/naf_field_decode.sv
module naf_field_decode
  import naf_pkg::*;
(
  input  logic [ADDR_W-1:F_LSB] addr,
  input  logic                  is_write,
  output naf_t                  fields
);
  always_comb begin
    fields.n = addr[N_LSB +: N_W];
    fields.a = addr[A_LSB +: A_W];
    fields.f = {is_write, addr[F_LSB +: F_W]};
  end
endmodule

// File: rtl/naf_op_classify.sv
module naf_op_classify
  import naf_pkg::*;
#(
  parameter int STATION_N = 24
) (
  input  logic      valid,
  input  logic [1:0] size,
  input  naf_t      fields,
  output logic      hit,
  output test_op_e  op
);
  localparam logic [N_W-1:0] STN = N_W'(STATION_N);
  localparam logic [F_W:0]   F16 = {1'b1, {F_W{1'b0}}};
  localparam logic [F_W:0]   F0  = '0;
  localparam logic [F_W:0]   F5  = (F_W+1)'(5);

  logic size_ok;

  always_comb begin
    size_ok = (size == SZ_WORD) || (size == SZ_LONG);
    hit     = valid && size_ok && (fields.n == STN);
    op      = OP_OTHER;
    if (fields.f == F16 && fields.a == A_W'(0)) op = OP_PING;
    if (fields.f == F16 && fields.a == A_W'(1)) op = OP_LOAD;
    if (fields.f == F0  && fields.a == A_W'(0)) op = OP_ZERO_RD;
    if (fields.f == F5  && fields.a == A_W'(1)) op = OP_FAST_RD;
  end
endmodule

// File: rtl/naf_test_counter.sv
module naf_test_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (load)               count <= load_val;
    else if (dec && count != '0) count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/naf_pulse_stretch.sv
module naf_pulse_stretch #(
  parameter int LEN = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (trig)          remain <= CW'(LEN);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign pulse = (remain != '0);
endmodule

// File: rtl/naf_test_station.sv
module naf_test_station
  import naf_pkg::*;
#(
  parameter int STATION_N  = 24,
  parameter int LAM_CYCLES = 40,
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_q,
  output logic              rsp_x,
  output logic              lam_pulse
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] MAGIC = HALF_W'(5);

  naf_t             fields;
  logic             hit;
  test_op_e         op;
  logic [CNT_W-1:0] count;
  logic             magic_seen;
  logic             nxt_q, nxt_x;
  logic [HALF_W-1:0] nxt_half;

  // Address byte lanes and upper write half do not steer this block.
  logic unused_bits;
  assign unused_bits = ^{req_addr[F_LSB-1:0], req_wdata[DATA_W-1:HALF_W]};

  naf_field_decode u_dec (
    .addr     (req_addr[ADDR_W-1:F_LSB]),
    .is_write (req_write),
    .fields   (fields)
  );

  naf_op_classify #(.STATION_N(STATION_N)) u_cls (
    .valid  (req_valid),
    .size   (req_size),
    .fields (fields),
    .hit    (hit),
    .op     (op)
  );

  naf_test_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (hit && op == OP_LOAD),
    .load_val (req_wdata[CNT_W-1:0]),
    .dec      (hit && op == OP_FAST_RD),
    .count    (count)
  );

  assign magic_seen = (req_wdata[HALF_W-1:0] == MAGIC);

  naf_pulse_stretch #(.LEN(LAM_CYCLES)) u_lam (
    .clk   (clk),
    .rst   (rst),
    .trig  (hit && op == OP_PING && magic_seen),
    .pulse (lam_pulse)
  );

  always_comb begin
    nxt_q    = 1'b0;
    nxt_x    = 1'b0;
    nxt_half = '0;
    unique case (op)
      OP_PING:    begin nxt_x = 1'b1; nxt_q = !magic_seen; end
      OP_LOAD:    begin nxt_x = 1'b1; nxt_q = 1'b1; end
      OP_ZERO_RD: begin nxt_x = 1'b1; nxt_q = 1'b1; end
      OP_FAST_RD: begin
        nxt_x    = 1'b1;
        nxt_q    = (count != '0);
        nxt_half = HALF_W'(count);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      rsp_ack   <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_x     <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= 1'b1;
      rsp_q     <= nxt_q;
      rsp_x     <= nxt_x;
      if (req_write)
        rsp_rdata <= '0;
      else if (req_size == SZ_LONG)
        rsp_rdata <= {nxt_half, nxt_half};
      else
        rsp_rdata <= {{HALF_W{1'b0}}, nxt_half};
    end
  end
endmodule

// File: rtl/naf_test_station_chk.sv
module naf_test_station_chk #(
  parameter int STATION_N = 24
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [14:0] req_addr,
  input logic [1:0]  req_size,
  input logic        req_write,
  input logic [15:0] wlo,
  input logic        rsp_ack,
  input logic [31:0] rsp_rdata,
  input logic        rsp_q,
  input logic        rsp_x,
  input logic        lam_pulse
);
  logic in_hit, is_ping5, is_fast, is_long_rd;
  logic [1:0] unused_lanes;
  assign unused_lanes = req_addr[1:0];

  assign in_hit     = req_valid && (req_size == 2'b01 || req_size == 2'b10)
                      && (req_addr[14:10] == 5'(STATION_N));
  assign is_ping5   = in_hit && req_write && req_addr[9:6] == 4'd0
                      && req_addr[5:2] == 4'd0 && wlo == 16'd5;
  assign is_fast    = in_hit && !req_write && req_addr[9:6] == 4'd1
                      && req_addr[5:2] == 4'd5;
  assign is_long_rd = in_hit && !req_write && req_size == 2'b10;

  assert_ack_source_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |-> $past(in_hit));

  assert_byte_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_size == 2'b00 || req_size == 2'b11)) |=> !rsp_ack);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !rsp_ack |-> (!rsp_q && !rsp_x && rsp_rdata == 32'd0));

  assert_q_with_x_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_q |-> rsp_x);

  assert_lam_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lam_pulse) |-> $past(is_ping5));

  assert_fast_q_R10: assert property (@(posedge clk) disable iff (rst)
    is_fast |=> (rsp_x && rsp_q == (rsp_rdata[3:0] != 4'd0)));

  assert_long_dup_R11: assert property (@(posedge clk) disable iff (rst)
    is_long_rd |=> (rsp_rdata[31:16] == rsp_rdata[15:0]));
endmodule

bind naf_test_station naf_test_station_chk #(.STATION_N(STATION_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_write (req_write),
  .wlo       (req_wdata[15:0]),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_q     (rsp_q),
  .rsp_x     (rsp_x),
  .lam_pulse (lam_pulse)
);

// File: tb/naf_test_station_tb_top.sv
module naf_test_station_tb_top;
  localparam int STN  = 24;
  localparam int LAMC = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [14:0] req_addr = '0;
  logic [1:0]  req_size = 2'b01;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack, rsp_q, rsp_x, lam_pulse;
  logic [31:0] rsp_rdata;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  int lam_run = 0;
  int lam_last = 0;

  typedef struct {
    int          due;
    bit          ack, q, x, chk_lam, lam;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  naf_test_station #(.STATION_N(STN), .LAM_CYCLES(LAMC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .rsp_q(rsp_q),
    .rsp_x(rsp_x), .lam_pulse(lam_pulse)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one request cycle, expected reply queued for the following cycle.
  task automatic access(input logic [1:0] sz, input bit wr, input int n,
                        input int a, input int f, input logic [1:0] lanes,
                        input logic [31:0] wd, input bit eack, input bit eq,
                        input bit ex, input logic [31:0] edata,
                        input bit chk_lam, input bit elam, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_size  = sz;
    req_write = wr;
    req_addr  = {5'(n), 4'(a), 4'(f), lanes};
    req_wdata = wd;
    e.due = cyc + 1; e.ack = eack; e.q = eq; e.x = ex; e.data = edata;
    e.chk_lam = chk_lam; e.lam = elam; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_ack == e.ack, e.tag, "ack", 32'(rsp_ack), 32'(e.ack));
        if (e.ack) begin
          check(rsp_q == e.q, e.tag, "q", 32'(rsp_q), 32'(e.q));
          check(rsp_x == e.x, e.tag, "x", 32'(rsp_x), 32'(e.x));
          check(rsp_rdata == e.data, e.tag, "rdata", rsp_rdata, e.data);
        end
        if (e.chk_lam)
          check(lam_pulse == e.lam, e.tag, "lam", 32'(lam_pulse), 32'(e.lam));
      end else if (rsp_ack) begin
        check(1'b0, "R4", "unexpected ack", 32'(rsp_ack), 32'd0);
      end
      if (lam_pulse) lam_run++;
      else if (lam_run > 0) begin lam_last = lam_run; lam_run = 0; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!rsp_ack && !lam_pulse && rsp_rdata == 0, "R4", "reset outputs",
          {rsp_rdata[29:0], rsp_ack, lam_pulse}, 32'd0);

    // R10: counter resets to 0, so first fast read gives 0 and no Q
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 0, 1, 32'd0, 0, 0, "R10 reset count");
    // R9 / R5: read A0 F0, word then longword with junk in lane bits (R1)
    access(2'b01, 0, STN, 0, 0, 2'b00, 0, 1, 1, 1, 32'd0, 0, 0, "R9 F0 word");
    access(2'b10, 0, STN, 0, 0, 2'b11, 0, 1, 1, 1, 32'd0, 0, 0, "R1 R9 F0 long lanes");
    // R6: ping with non-magic data, and with 5 only in upper half (R11)
    access(2'b01, 1, STN, 0, 0, 2'b00, 32'd7, 1, 1, 1, 0, 1, 0, "R6 ping");
    access(2'b10, 1, STN, 0, 0, 2'b00, 32'h0005_0000, 1, 1, 1, 0, 1, 0, "R11 R6 upper five");
    // R8 / R11: longword load, upper bits ignored
    access(2'b10, 1, STN, 1, 0, 2'b00, 32'hFFFF_FFF3, 1, 1, 1, 0, 0, 0, "R8 R11 load 3");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 1, 1, 32'd3, 0, 0, "R10 read 3");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 1, 1, 32'd2, 0, 0, "R10 read 2");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 1, 1, 32'd1, 0, 0, "R10 read 1");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 0, 1, 32'd0, 0, 0, "R10 read 0");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 0, 1, 32'd0, 0, 0, "R10 saturate");
    // R11: longword fast read duplicates halves
    access(2'b01, 1, STN, 1, 0, 2'b00, 32'd10, 1, 1, 1, 0, 0, 0, "R8 load 10");
    access(2'b10, 0, STN, 1, 5, 2'b00, 0, 1, 1, 1, 32'h000A_000A, 0, 0, "R11 long dup");
    // R2 / R3 / R12: loads that must not land
    access(2'b00, 1, STN, 1, 0, 2'b00, 32'd7, 0, 0, 0, 0, 0, 0, "R2 byte load");
    access(2'b11, 1, STN, 1, 0, 2'b00, 32'd7, 0, 0, 0, 0, 0, 0, "R2 reserved load");
    access(2'b01, 1, STN ^ 1, 1, 0, 2'b00, 32'd7, 0, 0, 0, 0, 0, 0, "R3 other station");
    access(2'b01, 1, STN, 2, 0, 2'b00, 32'd7, 1, 0, 0, 0, 0, 0, "R12 A2 F16");
    access(2'b01, 0, STN, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0, "R12 R5 A1 F0 read");
    access(2'b01, 0, STN, 0, 5, 2'b00, 0, 1, 0, 0, 0, 0, 0, "R12 A0 F5");
    access(2'b01, 0, STN, 1, 5, 2'b00, 0, 1, 1, 1, 32'd9, 0, 0, "R2 R3 R12 count kept");
    // R2 / R3: magic ping that must not land
    access(2'b00, 1, STN, 0, 0, 2'b00, 32'd5, 0, 0, 0, 0, 0, 0, "R2 byte ping");
    access(2'b01, 1, 3, 0, 0, 2'b00, 32'd5, 0, 0, 0, 0, 0, 0, "R3 ping other");
    repeat (3) @(negedge clk);
    check(!lam_pulse && lam_last == 0, "R2 R3 R6", "no lam", 32'(lam_last), 32'd0);

    // R7: magic ping, upper half junk, LAM length
    access(2'b10, 1, STN, 0, 0, 2'b00, 32'hABCD_0005, 1, 0, 1, 0, 1, 1, "R7 R11 ping five");
    repeat (LAMC + 5) @(posedge clk);
    check(lam_last == LAMC, "R7", "lam length", 32'(lam_last), 32'(LAMC));
    // R7: retrigger restarts the length
    lam_last = 0;
    access(2'b01, 1, STN, 0, 0, 2'b00, 32'd5, 1, 0, 1, 0, 1, 1, "R7 first");
    repeat (8) @(posedge clk);
    access(2'b01, 1, STN, 0, 0, 2'b00, 32'd5, 1, 0, 1, 0, 1, 1, "R7 retrigger");
    repeat (LAMC + 5) @(posedge clk);
    check(lam_last == LAMC + 10, "R7", "retrigger length", 32'(lam_last), 32'(LAMC + 10));

    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R4", "scoreboard drained", 32'(sb.size()), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule